// File: doc/BRIEF.md
# Four-point inverse sine transform

This block turns a vector of four signed transform coefficients into four reconstructed residual samples. It uses the integer asymmetric sine kernel of a modern video codec. The kernel works in 12-bit fixed point with four sine weights: w1 = 1321, w2 = 2482, w3 = 3344, w4 = 3803. It forms seven weighted products of the inputs plus one weighted auxiliary sum. It combines them in a fixed order, so that the product w3*x1 is shared by three of the four outputs. Each result is then reduced by a rounding arithmetic right shift.

Vectors enter and leave on valid/ready streams. Internally there is one register stage. A vector accepted on one clock edge is offered at the output from that edge on. A new vector can be taken on every cycle while the consumer keeps ready high. When the consumer stalls, the held result stays frozen. The input side deasserts ready in the same cycle, so back-pressure reaches the producer with no extra buffering. Inputs are 20-bit two's complement. Arithmetic is carried at 34 bits, and no combination of input values overflows it.

Top module: `ast4_inverse`

## Requirements
- R1: Sample 0 equals rnd(w1*x0 + w3*x1 + w4*x2 + w2*x3).
- R2: Sample 1 equals rnd(w2*x0 + w3*x1 - w1*x2 - w4*x3).
- R3: Sample 2 equals rnd(w3*(x0 - x2 + x3)).
- R4: Sample 3 equals rnd(A + B - w3*x1), where A is the R1 sum without its w3*x1 term and B is the R2 sum without its w3*x1 term.
- R5: rnd(v) adds 2^(S-1) to v and shifts it arithmetically right by S, with S = ROUND_SHIFT (default 12). Halves therefore round toward plus infinity, and negative values floor after the offset.
- R6: With ROUND_SHIFT = 0, each output equals its unrounded 34-bit sum, unchanged.
- R7: Coefficient k sits at in_coef[k*20 +: 20]. Sample k sits at out_samp[k*OUT_W +: OUT_W]. OUT_W is 34 - ROUND_SHIFT (22 by default). All lanes are two's complement.
- R8: A vector accepted on a clock edge (in_valid and in_ready both high) shows on out_samp with out_valid high right after that same edge.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_samp does not change.
- R10: in_ready is high exactly when out_valid is low or out_ready is high. With out_ready held high, one vector is accepted per cycle.
- R11: While rst_n is low, out_valid is low and in_ready is high.
- R12: Full-scale inputs (each of -2^19 and 2^19-1 in every lane) produce exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient vector present |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_coef | input | 80 | Four signed 20-bit coefficients, lane 0 in the low bits |
| out_valid | output | 1 | Sample vector present |
| out_ready | input | 1 | Consumer takes the vector this cycle |
| out_samp | output | 88 | Four signed 22-bit samples, lane 0 in the low bits |

## Verification
Every sample vector is due on the edge that follows its acceptance. It then stays due until a cycle in which out_ready is high. In the reference model, a vector accepted in one cycle is queued, and out_valid must be high exactly when that queue holds an entry. While out_valid is high, the queue front is compared lane by lane, half a period after each edge. Random valid and ready patterns exercise the stall and streaming cases. A second instance built with no rounding shift receives the same traffic and is checked against the raw sums.

// File: rtl/ast4_pkg.sv
package ast4_pkg;
  // Sine weights in 12-bit fixed point, indexed 1..4
  localparam int unsigned SINE_FRAC = 12;
  localparam int W1 = 1321;
  localparam int W2 = 2482;
  localparam int W3 = 3344;
  localparam int W4 = 3803;
  localparam int LANES = 4;
endpackage

// File: rtl/ast4_products.sv
// Stage 1: weighted products of the coefficient lanes and the auxiliary sum
module ast4_products
  import ast4_pkg::*;
#(
  parameter int IN_W  = 20,
  parameter int ACC_W = 34
) (
  input  logic signed [IN_W-1:0]  x0,
  input  logic signed [IN_W-1:0]  x1,
  input  logic signed [IN_W-1:0]  x2,
  input  logic signed [IN_W-1:0]  x3,
  output logic signed [ACC_W-1:0] p_w1x0,
  output logic signed [ACC_W-1:0] p_w2x0,
  output logic signed [ACC_W-1:0] p_w3x1,
  output logic signed [ACC_W-1:0] p_w4x2,
  output logic signed [ACC_W-1:0] p_w1x2,
  output logic signed [ACC_W-1:0] p_w2x3,
  output logic signed [ACC_W-1:0] p_w4x3,
  output logic signed [ACC_W-1:0] p_w3t
);
  localparam logic signed [ACC_W-1:0] K1 = ACC_W'(W1);
  localparam logic signed [ACC_W-1:0] K2 = ACC_W'(W2);
  localparam logic signed [ACC_W-1:0] K3 = ACC_W'(W3);
  localparam logic signed [ACC_W-1:0] K4 = ACC_W'(W4);

  logic signed [ACC_W-1:0] e0, e1, e2, e3;
  logic signed [ACC_W-1:0] aux_t;

  always_comb begin
    e0 = ACC_W'(x0);
    e1 = ACC_W'(x1);
    e2 = ACC_W'(x2);
    e3 = ACC_W'(x3);
    aux_t  = e0 - e2 + e3;
    p_w1x0 = K1 * e0;
    p_w2x0 = K2 * e0;
    p_w3x1 = K3 * e1;
    p_w4x2 = K4 * e2;
    p_w1x2 = K1 * e2;
    p_w2x3 = K2 * e3;
    p_w4x3 = K4 * e3;
    p_w3t  = K3 * aux_t;
  end
endmodule

// File: rtl/ast4_combine.sv
// Stage 2: accumulate the products into the four unrounded sums
module ast4_combine #(
  parameter int ACC_W = 34
) (
  input  logic signed [ACC_W-1:0] p_w1x0,
  input  logic signed [ACC_W-1:0] p_w2x0,
  input  logic signed [ACC_W-1:0] p_w3x1,
  input  logic signed [ACC_W-1:0] p_w4x2,
  input  logic signed [ACC_W-1:0] p_w1x2,
  input  logic signed [ACC_W-1:0] p_w2x3,
  input  logic signed [ACC_W-1:0] p_w4x3,
  input  logic signed [ACC_W-1:0] p_w3t,
  output logic signed [ACC_W-1:0] s0,
  output logic signed [ACC_W-1:0] s1,
  output logic signed [ACC_W-1:0] s2,
  output logic signed [ACC_W-1:0] s3
);
  logic signed [ACC_W-1:0] acc_a, acc_b;

  always_comb begin
    acc_a = p_w1x0 + p_w4x2 + p_w2x3;
    acc_b = p_w2x0 - p_w1x2 - p_w4x3;
    s0 = acc_a + p_w3x1;
    s1 = acc_b + p_w3x1;
    s2 = p_w3t;
    s3 = acc_a + acc_b - p_w3x1;
  end
endmodule

// File: rtl/ast4_round.sv
// Rounding arithmetic right shift of one lane; a zero shift is a pass-through
module ast4_round #(
  parameter int ACC_W = 34,
  parameter int SHIFT = 12,
  localparam int OUT_W = ACC_W - SHIFT
) (
  input  logic signed [ACC_W-1:0] v,
  output logic signed [OUT_W-1:0] r
);
  generate
    if (SHIFT == 0) begin : g_pass
      assign r = v;
    end else begin : g_shift
      localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SHIFT - 1);
      logic signed [ACC_W-1:0] biased;
      logic signed [ACC_W-1:0] shifted;
      logic signed [ACC_W+1:0] back;
      logic signed [ACC_W+1:0] resid;
      logic signed [ACC_W+1:0] half_w;

      always_comb begin
        biased  = v + HALF;
        shifted = biased >>> SHIFT;
      end
      assign r = shifted[OUT_W-1:0];

      // R5
      always_comb begin
        back   = (ACC_W+2)'(r) <<< SHIFT;
        resid  = (ACC_W+2)'(v) - back;
        half_w = (ACC_W+2)'(HALF);
        round_range_chk: assert (resid >= -half_w && resid < half_w);
      end
    end
  endgenerate
endmodule

// File: rtl/ast4_stage.sv
// Valid/ready output register: full throughput, stall holds the payload
module ast4_stage #(
  parameter int DW = 88
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  logic          held_q;
  logic [DW-1:0] data_q;

  assign up_ready = !held_q || dn_ready;
  assign dn_valid = held_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (up_ready) begin
      held_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) begin
      data_q <= up_data;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

  // R8
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);

  // R10
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !up_valid |=> !dn_valid);

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |-> !up_ready);
endmodule

// File: rtl/ast4_inverse.sv
module ast4_inverse
  import ast4_pkg::*;
#(
  parameter int IN_W        = 20,
  parameter int ACC_W       = 34,
  parameter int ROUND_SHIFT = SINE_FRAC,
  localparam int OUT_W      = ACC_W - ROUND_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*IN_W-1:0]  in_coef,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*OUT_W-1:0] out_samp
);
  logic signed [IN_W-1:0]  xl [LANES];
  logic signed [ACC_W-1:0] sl [LANES];
  logic signed [OUT_W-1:0] rl [LANES];
  logic [LANES*OUT_W-1:0]  packed_r;

  logic signed [ACC_W-1:0] q1x0, q2x0, q3x1, q4x2, q1x2, q2x3, q4x3, q3t;

  for (genvar k = 0; k < LANES; k++) begin : g_unpack
    assign xl[k] = in_coef[k*IN_W +: IN_W];
  end

  ast4_products #(.IN_W(IN_W), .ACC_W(ACC_W)) u_prod (
    .x0(xl[0]), .x1(xl[1]), .x2(xl[2]), .x3(xl[3]),
    .p_w1x0(q1x0), .p_w2x0(q2x0), .p_w3x1(q3x1), .p_w4x2(q4x2),
    .p_w1x2(q1x2), .p_w2x3(q2x3), .p_w4x3(q4x3), .p_w3t(q3t)
  );

  ast4_combine #(.ACC_W(ACC_W)) u_comb (
    .p_w1x0(q1x0), .p_w2x0(q2x0), .p_w3x1(q3x1), .p_w4x2(q4x2),
    .p_w1x2(q1x2), .p_w2x3(q2x3), .p_w4x3(q4x3), .p_w3t(q3t),
    .s0(sl[0]), .s1(sl[1]), .s2(sl[2]), .s3(sl[3])
  );

  // R4: the last sum differs from the first two by three shared products
  identity_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sl[3] == sl[0] + sl[1] - ((q3x1 <<< 1) + q3x1));

  for (genvar k = 0; k < LANES; k++) begin : g_round
    ast4_round #(.ACC_W(ACC_W), .SHIFT(ROUND_SHIFT)) u_rnd (
      .v(sl[k]),
      .r(rl[k])
    );
    assign packed_r[k*OUT_W +: OUT_W] = rl[k];
  end

  ast4_stage #(.DW(LANES*OUT_W)) u_stage (
    .clk(clk),
    .rst_n(rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data(packed_r),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data(out_samp)
  );
endmodule

// File: tb/ast4_inverse_test.sv
module ast4_inverse_test;
  localparam int IW = 20;
  localparam int OW = 22;
  localparam int RW = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [4*IW-1:0] in_coef = '0;
  logic in_ready, out_valid, in_ready_raw, out_valid_raw;
  logic [4*OW-1:0] out_samp;
  logic [4*RW-1:0] out_raw;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [255:0] q_rnd[$];
  logic [255:0] q_raw[$];

  always #10 clk = ~clk;

  ast4_inverse uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
    .out_samp(out_samp)
  );

  ast4_inverse #(.ROUND_SHIFT(0)) uut_noround (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_raw),
    .in_coef(in_coef), .out_valid(out_valid_raw), .out_ready(out_ready),
    .out_samp(out_raw)
  );

  function automatic void sums(input longint x0, x1, x2, x3, output longint s[4]);
    longint m;
    m = 3344 * x1;
    s[0] = 1321 * x0 + m + 3803 * x2 + 2482 * x3;
    s[1] = 2482 * x0 + m - 1321 * x2 - 3803 * x3;
    s[2] = 3344 * (x0 - x2 + x3);
    s[3] = (1321 * x0 + 3803 * x2 + 2482 * x3) + (2482 * x0 - 1321 * x2 - 3803 * x3) - m;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, settle, check, book the handshakes
  task automatic step(input bit iv, input longint x0, x1, x2, x3, input bit ordy);
    longint s[4];
    logic [255:0] er, ew;
    string lane_req[4] = '{"R1", "R2", "R3", "R4"};
    @(negedge clk);
    in_valid  = iv;
    out_ready = ordy;
    in_coef   = {IW'(x3), IW'(x2), IW'(x1), IW'(x0)}; // R7 lane order
    #1;
    check("R10", in_ready, !out_valid || out_ready);
    check("R8", out_valid, q_rnd.size() != 0);
    check("R6", out_valid_raw, q_raw.size() != 0);
    if (out_valid && q_rnd.size() != 0) begin
      for (int k = 0; k < 4; k++) begin
        check(lane_req[k], longint'($signed(out_samp[k*OW +: OW])),
              longint'($signed(q_rnd[0][k*64 +: 64])));
        check("R6", longint'($signed(out_raw[k*RW +: RW])),
              longint'($signed(q_raw[0][k*64 +: 64])));
      end
      if (out_ready) begin
        void'(q_rnd.pop_front());
        void'(q_raw.pop_front());
      end
    end
    if (iv && in_ready) begin
      sums(x0, x1, x2, x3, s);
      for (int k = 0; k < 4; k++) begin
        ew[k*64 +: 64] = s[k];
        er[k*64 +: 64] = (s[k] + 2048) >>> 12; // R5
      end
      q_rnd.push_back(er);
      q_raw.push_back(ew);
    end
  endtask

  function automatic longint rnd_in();
    return longint'($signed(IW'($urandom)));
  endfunction

  initial begin
    longint mx, mn;
    mx = (1 <<< 19) - 1;
    mn = -(1 <<< 19);
    // R11: reset state
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R11", out_valid, 0);
      check("R11", in_ready, 1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1-style unit vectors per lane, streaming one per cycle (R10)
    step(1, 1, 0, 0, 0, 1);
    step(1, 0, 1, 0, 0, 1);
    step(1, 0, 0, 1, 0, 1);
    step(1, 0, 0, 0, 1, 1);
    step(1, -1, 0, 0, 0, 1);
    // R5: values near the rounding boundary and negative halves
    step(1, 3, -2, 5, 7, 1);
    step(1, -5, 11, -3, 2, 1);
    step(1, 1000, -1000, 1000, -1000, 1);
    // R9: stall with a held result
    step(1, 77, -33, 12, 9, 1);
    step(1, 5, 6, 7, 8, 0);
    step(1, 9, 9, 9, 9, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // R12: full-scale corners
    for (int i = 0; i < 16; i++)
      step(1, i[0] ? mx : mn, i[1] ? mx : mn, i[2] ? mx : mn, i[3] ? mx : mn, 1);
    step(1, mx, mn, mn, mx, 1);
    step(1, mn, mx, mx, mn, 1);
    // random traffic with random back-pressure (R8, R9, R10)
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, rnd_in(), rnd_in(), rnd_in(), rnd_in(), ($urandom % 3) != 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule